// File: doc/BRIEF.md
# Per-Half-Cycle Authorised PWM Gate Driver

This block drives the gate of a mains power switch with a fast, centre-aligned PWM carrier that may only run inside mains half-cycles the host has explicitly authorised. A one-clock zero-cross pulse marks the start of each half-cycle. That pulse turns the gate off and throws away any duty value that was in force or waiting. From then on the host must deliver a fresh duty word over a valid/ready load port. Until it does, the switch stays off.

A duty word is a single-use token. It takes effect at the next carrier period boundary and lasts only until the next zero crossing. A host that goes quiet therefore leaves the switch off rather than on.

An asynchronous trip input is used for current faults and for the mute override. It forces both the gate and its complement low at once and latches until reset. A power-good flag tells the rest of the system that the supply has been fed correctly for a run of consecutive half-cycles.

Top module: `mains_pwm_gate`

## Requirements
- R1: The carrier counter runs through PERIOD clocks (0 to PERIOD-1, default 160) and is restarted at 0 by the clock edge that samples `zero_cross` high.
- R2: For an active duty d with 0 < d < PERIOD, `gate` is high for exactly d consecutive carrier counts starting at count (PERIOD-d)/2 (integer division). The pulse is centred in each period and appears one clock after the counter value that selects it.
- R3: Duty 0 keeps `gate` low for the whole period, and any duty value at or above PERIOD keeps it high for the whole period.
- R4: The edge that samples `zero_cross` high drives `gate` low and discards both the active and the pending duty word. In a half-cycle in which no word is accepted, `gate` stays low throughout.
- R5: A word accepted on `duty_valid && duty_ready` becomes pending. It turns active at the first edge at which the counter is PERIOD-1 and the word was already pending before that edge. A word accepted together with `zero_cross` belongs to the new half-cycle.
- R6: While no trip is latched, `gate_n` is the exact complement of `gate`.
- R7: When `trip` rises, `gate` and `gate_n` both go low without waiting for a clock edge. They stay low, with `duty_ready` low and loads ignored, until `rst_n` is asserted.
- R8: `power_ok` rises only after HALVES consecutive zero crossings (default 3), each closing a half-cycle in which a word was accepted and no trip was latched. A zero crossing closing a half-cycle without a word clears the run. `power_ok` is low whenever a trip is latched.
- R9: While `rst_n` is low, `gate`=0, `gate_n`=1, `power_ok`=0 and `duty_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz class) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| zero_cross | input | 1 | One-clock pulse at each mains zero crossing |
| duty_valid | input | 1 | Host presents a duty word |
| duty_word | input | DUTY_W | Duty in carrier counts; 0 is off, PERIOD or more is fully on |
| duty_ready | output | 1 | Block accepts a word (low while tripped) |
| trip | input | 1 | Asynchronous fault/mute request, latched until reset |
| gate | output | 1 | Centre-aligned PWM switch drive |
| gate_n | output | 1 | Complementary drive, low while tripped |
| power_ok | output | 1 | Supply has been fed correctly for HALVES half-cycles |

## Verification
The hardest situations to reach are the races between a load and the events around it. One is a word arriving on the very edge where the carrier wraps. The other is a word arriving in the same cycle as the zero crossing. In both, the pending and active tokens have to be ordered correctly. The bench places the load strobe on an exact edge index counted from the zero-cross pulse, including edge 0 and edge PERIOD. A cycle-accurate model then predicts every gate sample. The trip is raised between clock edges, so the next sample shows whether it acted without a clock.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  // Centre-aligned window: true when carrier count c falls inside a pulse
  // of width d placed symmetrically in a period of p counts.
  function automatic logic in_window(input int unsigned c,
                                     input int unsigned d,
                                     input int unsigned p);
    int unsigned lo;
    if (d == 0) return 1'b0;
    if (d >= p) return 1'b1;
    lo = (p - d) / 2;
    return (c >= lo) && (c < lo + d);
  endfunction
endpackage

// File: rtl/mpg_carrier.sv
module mpg_carrier #(
  parameter int PERIOD = 160,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_nx;

  assign wrap = (cnt == CNT_W'(PERIOD - 1));

  always_comb begin
    if (zc)        cnt_nx = '0;
    else if (wrap) cnt_nx = '0;
    else           cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(PERIOD));
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    zc |=> (cnt == '0));
endmodule

// File: rtl/mpg_token.sv
module mpg_token #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc,
  input  logic              wrap,
  input  logic              load,
  input  logic [DUTY_W-1:0] load_duty,
  output logic              act_val,
  output logic [DUTY_W-1:0] act_duty,
  output logic              got_word
);
  logic              pend_val, pend_nx, act_nx, got_nx;
  logic [DUTY_W-1:0] pend_duty, pdu_nx, duty_nx;

  always_comb begin
    act_nx  = act_val;
    duty_nx = act_duty;
    pend_nx = pend_val;
    pdu_nx  = pend_duty;
    got_nx  = got_word;
    if (zc) begin
      act_nx  = 1'b0;
      pend_nx = load;
      pdu_nx  = load_duty;
      got_nx  = load;
    end else begin
      if (wrap && pend_val) begin
        act_nx  = 1'b1;
        duty_nx = pend_duty;
        pend_nx = 1'b0;
      end
      if (load) begin
        pend_nx = 1'b1;
        pdu_nx  = load_duty;
        got_nx  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_val   <= 1'b0;
      act_duty  <= '0;
      pend_val  <= 1'b0;
      pend_duty <= '0;
      got_word  <= 1'b0;
    end else begin
      act_val   <= act_nx;
      act_duty  <= duty_nx;
      pend_val  <= pend_nx;
      pend_duty <= pdu_nx;
      got_word  <= got_nx;
    end
  end

  a_r4_token_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    zc |=> !act_val);
  a_r5_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_val) |-> $past(wrap));
endmodule

// File: rtl/mpg_ready.sv
module mpg_ready #(
  parameter int HALVES = 3,
  localparam int SW = $clog2(HALVES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc,
  input  logic got_word,
  input  logic tripped,
  output logic power_ok
);
  logic [SW-1:0] streak, streak_nx;

  always_comb begin
    streak_nx = streak;
    if (zc) begin
      if (got_word && !tripped)
        streak_nx = (streak == SW'(HALVES)) ? streak : streak + 1'b1;
      else
        streak_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) streak <= '0;
    else        streak <= streak_nx;
  end

  assign power_ok = (streak >= SW'(HALVES)) && !tripped;

  a_r8_rise_at_zc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_ok) |-> $past(zc));
endmodule

// File: rtl/mains_pwm_gate.sv
module mains_pwm_gate #(
  parameter int PERIOD = 160,
  parameter int DUTY_W = 8,
  parameter int HALVES = 3,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_cross,
  input  logic              duty_valid,
  input  logic [DUTY_W-1:0] duty_word,
  output logic              duty_ready,
  input  logic              trip,
  output logic              gate,
  output logic              gate_n,
  output logic              power_ok
);
  import mpg_pkg::*;

  logic [CNT_W-1:0]  cnt;
  logic              wrap, act_val, got_word, tripped, load;
  logic [DUTY_W-1:0] act_duty;
  logic              gate_q, gate_nx;

  // Fault latch: set without a clock, cleared only by reset.
  always_ff @(posedge clk or negedge rst_n or posedge trip) begin
    if (!rst_n)    tripped <= 1'b0;
    else if (trip) tripped <= 1'b1;
  end

  assign duty_ready = !tripped;
  assign load       = duty_valid && duty_ready;

  mpg_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk(clk), .rst_n(rst_n), .zc(zero_cross), .cnt(cnt), .wrap(wrap));

  mpg_token #(.DUTY_W(DUTY_W)) u_token (
    .clk(clk), .rst_n(rst_n), .zc(zero_cross), .wrap(wrap), .load(load),
    .load_duty(duty_word), .act_val(act_val), .act_duty(act_duty),
    .got_word(got_word));

  mpg_ready #(.HALVES(HALVES)) u_ready (
    .clk(clk), .rst_n(rst_n), .zc(zero_cross), .got_word(got_word),
    .tripped(tripped), .power_ok(power_ok));

  always_comb begin
    if (zero_cross) gate_nx = 1'b0;
    else gate_nx = act_val && in_window(32'(cnt), 32'(act_duty), PERIOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_nx;
  end

  assign gate   = gate_q  && !tripped;
  assign gate_n = !gate_q && !tripped;

  a_r4_zc_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cross |=> !gate);
  a_r7_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (!gate && !gate_n && !duty_ready));
  a_r7_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_ready |=> !duty_ready);
endmodule

// File: tb/test_mains_pwm_gate.sv
module test_mains_pwm_gate;
  localparam int CLK_PERIOD = 10;
  localparam int P = 160;
  localparam int NH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_zc = 1'b0, in_v = 1'b0, in_trip = 1'b0;
  logic [7:0] in_d = '0;
  logic duty_ready, gate, gate_n, power_ok;

  mains_pwm_gate i_mains_pwm_gate (
    .clk(clk), .rst_n(rst_n), .zero_cross(in_zc), .duty_valid(in_v),
    .duty_word(in_d), .duty_ready(duty_ready), .trip(in_trip),
    .gate(gate), .gate_n(gate_n), .power_ok(power_ok));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic g, gn, pok, rdy;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  int m_cnt, m_ad, m_pd, m_streak;
  bit m_act, m_pend, m_got, m_trip;

  function automatic bit win(int c, int d);
    int lo;
    if (d == 0) return 1'b0;
    if (d >= P) return 1'b1;
    lo = (P - d) / 2;
    return (c >= lo) && (c < lo + d);
  endfunction

  task automatic check1(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ad = 0; m_pd = 0; m_streak = 0;
    m_act = 0; m_pend = 0; m_got = 0; m_trip = 0;
  endtask

  // One clock edge: update the reference model with the inputs held over
  // that edge, push the expected outputs, then clear the strobes.
  task automatic tick(string tag, bit do_trip);
    exp_t e;
    bit g, ld;
    @(posedge clk); #2;
    ld = in_v && !m_trip;
    g = m_trip ? 1'b0 : (in_zc ? 1'b0 : (m_act && win(m_cnt, m_ad)));
    if (in_zc) begin
      if (m_got && !m_trip) m_streak = (m_streak < NH) ? m_streak + 1 : NH;
      else m_streak = 0;
      m_got = ld; m_act = 0; m_pend = ld; m_pd = in_d;
    end else begin
      if (m_cnt == P - 1 && m_pend) begin m_act = 1; m_ad = m_pd; m_pend = 0; end
      if (ld) begin m_pend = 1; m_pd = in_d; m_got = 1; end
    end
    m_cnt = in_zc ? 0 : ((m_cnt == P - 1) ? 0 : m_cnt + 1);
    if (do_trip) begin in_trip = 1'b1; m_trip = 1; end
    else in_trip = 1'b0;
    e.g = g & !m_trip;
    e.gn = !g & !m_trip;
    e.pok = (m_streak >= NH) && !m_trip;
    e.rdy = !m_trip;
    e.tag = tag;
    q.push_back(e);
    in_zc = 1'b0; in_v = 1'b0;
  endtask

  // Half-cycle: zero-cross pulse, optional load at edge index lj, trip at tj.
  task automatic half(int dw, bit give, int lj, int len, int tj, string tag);
    in_zc = 1'b1;
    if (give && lj == 0) begin in_v = 1'b1; in_d = 8'(dw); end
    tick(tag, 1'b0);
    for (int j = 1; j <= len; j++) begin
      if (give && j == lj) begin in_v = 1'b1; in_d = 8'(dw); end
      tick(tag, j == tj);
    end
  endtask

  task automatic reset_check(string tag);
    check1(tag, "gate", gate, 1'b0);
    check1(tag, "gate_n", gate_n, 1'b1);
    check1(tag, "power_ok", power_ok, 1'b0);
    check1(tag, "duty_ready", duty_ready, 1'b1);
  endtask

  // Monitor: compare each expected item half a clock after its edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check1(e.tag, "gate", gate, e.g);
        check1(e.tag, "gate_n", gate_n, e.gn);
        check1(e.tag, "power_ok", power_ok, e.pok);
        check1(e.tag, "duty_ready", duty_ready, e.rdy);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    #(CLK_PERIOD * 3 + 1);
    reset_check("R9 reset");
    @(posedge clk); #2; rst_n = 1'b1;
    half(80, 1, 5, 2*P + 20, 0, "R2 R5 mid load");
    half(0, 0, 0, 2*P + 20, 0, "R4 no word");
    half(0, 1, 3, 2*P + 20, 0, "R3 zero duty");
    half(200, 1, 3, 2*P + 20, 0, "R3 full duty");
    half(1, 1, 7, 2*P + 20, 0, "R2 min duty");
    half(159, 1, 0, 2*P + 20, 0, "R5 zc cycle load");
    half(40, 1, P, 3*P, 0, "R5 boundary edge load");
    half(120, 1, 200, 3*P, 0, "R1 R6 late load");
    half(90, 1, 4, 2*P, 0, "R8 run");
    half(0, 0, 0, 2*P, 0, "R8 drop");
    half(70, 1, 2, P, 0, "R8 rebuild");
    half(70, 1, 2, P, 0, "R8 rebuild");
    half(70, 1, 2, P, 0, "R8 rebuild");
    half(70, 1, 2, P, 0, "R8 ready");
    half(100, 1, 2, 2*P + 20, 250, "R7 trip");
    half(50, 1, 3, 2*P, 0, "R7 held");
    @(posedge clk); #2; rst_n = 1'b0;
    #(CLK_PERIOD * 2);
    reset_check("R9 second reset");
    model_reset();
    @(posedge clk); #2; rst_n = 1'b1;
    half(80, 1, 5, 2*P + 20, 0, "R9 after reset");
    @(posedge clk); @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule